// File: doc/BRIEF.md
# Next-PC Unit for Equality Branches and Segment Jumps

This block holds the program counter of a simple in-order core and works out the address of the next instruction every cycle. It looks at the current 32-bit instruction word and at the values of its two source registers. From these it picks one of three next addresses. The first is the sequential one, four bytes on. The second is a PC-relative branch target, used for branch-if-equal and branch-if-not-equal. The third is a jump target inside the current 256 MB address segment.

The core presents the instruction fetched at `pc` together with both register values. The unit shows `pc_plus4` and a `taken` flag at once, without a clock edge. On the next rising clock edge with `en` high, `pc` moves to the chosen address. With `en` low, `pc` holds its value, which lets the core stall.

The opcode sits in bits 31:26 of the instruction word. Opcode 4 means branch-if-equal, opcode 5 means branch-if-not-equal and opcode 2 means jump. Every other opcode advances the PC sequentially.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and afterwards until the first enabled edge, `pc` is `RESET_PC` (default 0).
- R2: `pc_plus4` always equals `pc + 4` (modulo 2^32).
- R3: For any opcode other than 2, 4 or 5, `taken` is 0 and an enabled edge loads `pc + 4`. The register values and the remaining instruction bits have no effect.
- R4: For opcode 4 (branch-if-equal), `taken` is 1 exactly when `rs_val == rt_val`. When taken, an enabled edge loads `pc + 4 + 4*sext(instr[15:0])`; otherwise it loads `pc + 4`.
- R5: For opcode 5 (branch-if-not-equal), `taken` is 1 exactly when `rs_val != rt_val`. The target is the same as in R4; when not taken the PC advances by 4.
- R6: The 16-bit offset is signed, so offsets 0x8000 to 0xFFFF branch backwards (0x8000 gives `pc + 4 - 0x20000`).
- R7: For opcode 2 (jump), `taken` is 1 and an enabled edge loads `{(pc+4)[31:28], instr[25:0], 2'b00}`. The upper four bits come from `pc + 4`, not from `pc`.
- R8: With `en` low, `pc` keeps its value for any instruction, and `taken` still reports the decision.
- R9: Bits 1:0 of `pc` are always 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance enable; low stalls the PC |
| instr | input | 32 | Instruction word at the current PC |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential address, pc + 4 |
| taken | output | 1 | Control transfer selected for this instruction |

## Verification
The bench builds the unit with its default parameters: a 32-bit address, the direct equality comparator, asynchronous reset and reset address 0. The full 32-bit width lets a jump land on the last word of a 256 MB segment. A following jump from there must then take its upper bits from the next segment. The bench sweeps every one of the 64 opcodes, and it sweeps a window of branch offsets around zero for both branch kinds with equal and unequal operands. It also drives both offset extremes and the worked loop addresses (a branch at 80012 reaching 80024, and a jump field of 20000 reaching 80000).

// File: rtl/npc_pkg.sv
`timescale 1ns/1ps
package npc_pkg;

   // kind of control flow selected for the current instruction
   typedef enum logic [1:0] {
      CF_SEQ = 2'd0,
      CF_BEQ = 2'd1,
      CF_BNE = 2'd2,
      CF_JMP = 2'd3
   } cf_kind_t;

   localparam int unsigned OPC_W      = 6;
   localparam int unsigned INSTR_W    = 32;
   localparam int unsigned IMM_W      = 16;
   localparam int unsigned JFIELD_W   = INSTR_W - OPC_W;
   localparam logic [OPC_W-1:0] OPC_JMP = 6'd2;
   localparam logic [OPC_W-1:0] OPC_BEQ = 6'd4;
   localparam logic [OPC_W-1:0] OPC_BNE = 6'd5;

endpackage

// File: rtl/npc_decode.sv
`timescale 1ns/1ps
module npc_decode
   import npc_pkg::*;
#(
   parameter int unsigned IW = INSTR_W,
   parameter int unsigned OW = OPC_W,
   parameter int unsigned MW = IMM_W,
   parameter logic [OW-1:0] OP_EQ = OPC_BEQ,
   parameter logic [OW-1:0] OP_NE = OPC_BNE,
   parameter logic [OW-1:0] OP_J  = OPC_JMP
) (
   input  logic [IW-1:0]    instr,
   output cf_kind_t         kind,
   output logic [MW-1:0]    imm,
   output logic [IW-OW-1:0] jfield
);

   localparam int unsigned FW = IW - OW;

   generate
      if (OW >= IW) begin : g_bad_opc
         $error("npc_decode: opcode width must be below instruction width");
      end
      if (MW > FW) begin : g_bad_imm
         $error("npc_decode: immediate does not fit below the opcode");
      end
      if (OP_EQ == OP_NE || OP_EQ == OP_J || OP_NE == OP_J) begin : g_bad_codes
         $error("npc_decode: control opcodes must be distinct");
      end
   endgenerate

   logic [OW-1:0] opc;

   assign opc    = instr[IW-1 -: OW];
   assign imm    = instr[MW-1:0];
   assign jfield = instr[FW-1:0];

   always_comb begin
      if (opc == OP_EQ) begin
         kind = CF_BEQ;
      end else if (opc == OP_NE) begin
         kind = CF_BNE;
      end else if (opc == OP_J) begin
         kind = CF_JMP;
      end else begin
         kind = CF_SEQ;
      end
   end

endmodule

// File: rtl/npc_compare.sv
`timescale 1ns/1ps
module npc_compare #(
   parameter int unsigned DW      = 32,
   parameter int unsigned EQ_IMPL = 0   // 0: direct compare, 1: xor reduction tree
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic          same
);

   generate
      if (DW < 1) begin : g_bad_dw
         $error("npc_compare: width must be at least one");
      end
      if (EQ_IMPL > 1) begin : g_bad_impl
         $error("npc_compare: unknown comparator variant");
      end

      if (EQ_IMPL == 0) begin : g_direct
         assign same = (a == b);
      end else begin : g_tree
         logic [DW-1:0] diff;
         for (genvar i = 0; i < DW; i++) begin : g_bit
            assign diff[i] = a[i] ^ b[i];
         end
         assign same = ~|diff;
      end
   endgenerate

endmodule

// File: rtl/npc_target.sv
`timescale 1ns/1ps
module npc_target #(
   parameter int unsigned AW   = 32,
   parameter int unsigned MW   = 16,
   parameter int unsigned FW   = 26,
   parameter int unsigned SEGW = 4
) (
   input  logic [AW-1:0] pc,
   input  logic [MW-1:0] imm,
   input  logic [FW-1:0] jfield,
   output logic [AW-1:0] seq_pc,
   output logic [AW-1:0] br_pc,
   output logic [AW-1:0] jmp_pc
);

   localparam int unsigned SEXT_W = AW - MW - 2;

   generate
      if (SEGW + FW + 2 != AW) begin : g_bad_jump
         $error("npc_target: segment bits plus jump field plus two must equal address width");
      end
      if (MW + 2 > AW) begin : g_bad_off
         $error("npc_target: scaled offset wider than address");
      end
   endgenerate

   logic [AW-1:0] off_bytes;

   assign seq_pc = pc + AW'(4);

   // sign-extended word offset, scaled to bytes
   generate
      if (SEXT_W > 0) begin : g_sext
         assign off_bytes = {{SEXT_W{imm[MW-1]}}, imm, 2'b00};
      end else begin : g_nosext
         assign off_bytes = {imm, 2'b00};
      end
   endgenerate

   assign br_pc  = seq_pc + off_bytes;
   assign jmp_pc = {seq_pc[AW-1 -: SEGW], jfield, 2'b00};

endmodule

// File: rtl/npc_pcreg.sv
`timescale 1ns/1ps
module npc_pcreg #(
   parameter int unsigned AW        = 32,
   parameter logic [AW-1:0] RST_VAL = '0,
   parameter bit          ASYNC_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [AW-1:0] nxt,
   output logic [AW-1:0] q
);

   generate
      if (RST_VAL[1:0] != 2'b00) begin : g_bad_rst
         $error("npc_pcreg: reset address must be word aligned");
      end

      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= RST_VAL;
            end else if (en) begin
               q <= nxt;
            end
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               q <= RST_VAL;
            end else if (en) begin
               q <= nxt;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/npc_unit.sv
`timescale 1ns/1ps
module npc_unit
   import npc_pkg::*;
#(
   parameter int unsigned   ADDR_W    = 32,
   parameter int unsigned   DATA_W    = 32,
   parameter int unsigned   SEG_BITS  = 4,
   parameter int unsigned   EQ_IMPL   = 0,
   parameter bit            ASYNC_RST = 1'b1,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0]  rs_val,
   input  logic [DATA_W-1:0]  rt_val,
   output logic [ADDR_W-1:0]  pc,
   output logic [ADDR_W-1:0]  pc_plus4,
   output logic               taken
);

   generate
      if (ADDR_W < 8) begin : g_bad_aw
         $error("npc_unit: address width too small");
      end
   endgenerate

   cf_kind_t            kind;
   logic [IMM_W-1:0]    imm;
   logic [JFIELD_W-1:0] jfield;
   logic                regs_eq;
   logic [ADDR_W-1:0]   br_pc;
   logic [ADDR_W-1:0]   jmp_pc;
   logic [ADDR_W-1:0]   pc_nxt;
   logic                br_hit;

   npc_decode #(
      .IW(INSTR_W), .OW(OPC_W), .MW(IMM_W),
      .OP_EQ(OPC_BEQ), .OP_NE(OPC_BNE), .OP_J(OPC_JMP)
   ) u_dec (
      .instr  (instr),
      .kind   (kind),
      .imm    (imm),
      .jfield (jfield)
   );

   npc_compare #(.DW(DATA_W), .EQ_IMPL(EQ_IMPL)) u_cmp (
      .a    (rs_val),
      .b    (rt_val),
      .same (regs_eq)
   );

   npc_target #(
      .AW(ADDR_W), .MW(IMM_W), .FW(JFIELD_W), .SEGW(SEG_BITS)
   ) u_tgt (
      .pc     (pc),
      .imm    (imm),
      .jfield (jfield),
      .seq_pc (pc_plus4),
      .br_pc  (br_pc),
      .jmp_pc (jmp_pc)
   );

   always_comb begin
      case (kind)
         CF_BEQ:  br_hit = regs_eq;
         CF_BNE:  br_hit = ~regs_eq;
         default: br_hit = 1'b0;
      endcase
   end

   assign taken = br_hit | (kind == CF_JMP);

   always_comb begin
      if (kind == CF_JMP) begin
         pc_nxt = jmp_pc;
      end else if (br_hit) begin
         pc_nxt = br_pc;
      end else begin
         pc_nxt = pc_plus4;
      end
   end

   npc_pcreg #(
      .AW(ADDR_W), .RST_VAL(RESET_PC), .ASYNC_RST(ASYNC_RST)
   ) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (en),
      .nxt   (pc_nxt),
      .q     (pc)
   );

endmodule

// File: rtl/npc_unit_chk.sv
`timescale 1ns/1ps
module npc_unit_chk #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned SEG_BITS = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en,
   input logic [31:0]       instr,
   input logic [DATA_W-1:0] rs_val,
   input logic [DATA_W-1:0] rt_val,
   input logic [ADDR_W-1:0] pc,
   input logic [ADDR_W-1:0] pc_plus4,
   input logic              taken
);

   logic       live;
   logic [5:0] opc;
   logic [ADDR_W-1:0] off_b;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live <= 1'b0;
      else        live <= 1'b1;
   end

   assign opc   = instr[31:26];
   assign off_b = {{(ADDR_W-18){instr[15]}}, instr[15:0], 2'b00};

   // R1
   reset_value_chk: assert property (@(posedge clk) !rst_n |=> (pc == '0) || rst_n);

   // R3
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live && en && !taken |=> pc == $past(pc_plus4));

   // R3
   seq_not_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opc != 6'd2 && opc != 6'd4 && opc != 6'd5) |-> !taken);

   // R4
   beq_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live && en && opc == 6'd4 && rs_val == rt_val |=> pc == $past(pc_plus4) + $past(off_b));

   // R5
   bne_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == 6'd5 && rs_val == rt_val) |-> !taken);

   // R7
   jump_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live && en && opc == 6'd2 |=>
      pc == {$past(pc_plus4[ADDR_W-1 -: SEG_BITS]), $past(instr[25:0]), 2'b00});

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      live && !en |=> $stable(pc));

   // R9
   align_chk: assert property (@(posedge clk) disable iff (!rst_n) pc[1:0] == 2'b00);

endmodule

bind npc_unit npc_unit_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEG_BITS(SEG_BITS)
) u_npc_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .en       (en),
   .instr    (instr),
   .rs_val   (rs_val),
   .rt_val   (rt_val),
   .pc       (pc),
   .pc_plus4 (pc_plus4),
   .taken    (taken)
);

// File: tb/test_npc_unit.sv
`timescale 1ns/1ps
module test_npc_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [31:0] pc;
   logic [31:0] pc_plus4;
   logic        taken;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_pc = '0;

   always #4 clk = ~clk;   // 125 MHz

   npc_unit i_npc_unit (
      .clk(clk), .rst_n(rst_n), .en(en), .instr(instr),
      .rs_val(rs_val), .rt_val(rt_val),
      .pc(pc), .pc_plus4(pc_plus4), .taken(taken)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [15:0] off);
      return {op, 5'd9, 5'd10, off};
   endfunction

   function automatic logic [31:0] mk_j(input logic [25:0] f);
      return {6'd2, f};
   endfunction

   function automatic logic [31:0] br_dest(input logic [31:0] p, input logic [15:0] off);
      return p + 32'd4 + 32'(4 * $signed(off));
   endfunction

   function automatic logic [31:0] j_dest(input logic [31:0] p, input logic [25:0] f);
      logic [31:0] s;
      s = p + 32'd4;
      return {s[31:28], f, 2'b00};
   endfunction

   // one instruction: check combinational outputs, then the PC after the edge
   task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic e, input logic tk, input logic [31:0] nxt, input string req);
      @(negedge clk);
      instr = ins; rs_val = a; rt_val = b; en = e;
      #1;
      chk(pc_plus4 == exp_pc + 32'd4, "R2", pc_plus4, exp_pc + 32'd4);
      chk(taken == tk, req, {31'd0, taken}, {31'd0, tk});
      @(posedge clk);
      #1;
      chk(pc == nxt, req, pc, nxt);
      chk(pc[1:0] == 2'b00, "R9", pc, {pc[31:2], 2'b00});
      exp_pc = nxt;
   endtask

   task automatic go_to(input logic [25:0] f);
      step(mk_j(f), '0, '0, 1'b1, 1'b1, j_dest(exp_pc, f), "R7");
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] ins;
      logic [15:0] off;
      repeat (3) @(posedge clk);
      #1;
      chk(pc == 32'd0, "R1", pc, 32'd0);
      chk(pc_plus4 == 32'd4, "R2", pc_plus4, 32'd4);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk(pc == 32'd0, "R1", pc, 32'd0);

      // R3: every opcode except the control ones advances by four
      for (int op = 0; op < 64; op++) begin
         if (op != 2 && op != 4 && op != 5) begin
            ins = {op[5:0], 26'h2A5_5A5A};
            step(ins, 32'h1234, 32'h1234, 1'b1, 1'b0, exp_pc + 32'd4, "R3");
            step(ins, 32'h1234, 32'h4321, 1'b1, 1'b0, exp_pc + 32'd4, "R3");
         end
      end

      // R8: stall holds for jump and for a taken branch
      step(mk_j(26'h155), '0, '0, 1'b0, 1'b1, exp_pc, "R8");
      step(mk_i(6'd4, 16'h0010), 32'd7, 32'd7, 1'b0, 1'b1, exp_pc, "R8");
      step(32'h0232_4020, '0, '0, 1'b0, 1'b0, exp_pc, "R8");

      // worked loop: jump field 20000 gives 80000, branch at 80012 offset 2 gives 80024
      go_to(26'd20000);
      chk(pc == 32'd80000, "R7", pc, 32'd80000);
      step(32'h0013_4880, '0, '0, 1'b1, 1'b0, 32'd80004, "R3");
      step(32'h0136_4820, '0, '0, 1'b1, 1'b0, 32'd80008, "R3");
      step(32'h8D28_0000, '0, '0, 1'b1, 1'b0, 32'd80012, "R3");
      step(mk_i(6'd5, 16'd2), 32'd1, 32'd2, 1'b1, 1'b1, 32'd80024, "R5");
      go_to(26'd20000);
      chk(pc == 32'd80000, "R7", pc, 32'd80000);

      // R4 R5 R6: offset window around zero, both kinds, both outcomes
      for (int k = -16; k <= 16; k++) begin
         off = 16'(k);
         go_to(26'h10_0000);
         step(mk_i(6'd4, off), 32'hAA, 32'hAA, 1'b1, 1'b1, br_dest(exp_pc, off), k < 0 ? "R6" : "R4");
         go_to(26'h10_0000);
         step(mk_i(6'd4, off), 32'hAA, 32'hAB, 1'b1, 1'b0, exp_pc + 32'd4, "R4");
         go_to(26'h10_0000);
         step(mk_i(6'd5, off), 32'h8000_0000, 32'h0, 1'b1, 1'b1, br_dest(exp_pc, off), k < 0 ? "R6" : "R5");
         go_to(26'h10_0000);
         step(mk_i(6'd5, off), 32'h55, 32'h55, 1'b1, 1'b0, exp_pc + 32'd4, "R5");
      end

      // R6: offset extremes from 0x00400000
      go_to(26'h10_0000);
      step(mk_i(6'd4, 16'h7FFF), '1, '1, 1'b1, 1'b1, 32'h0042_0000, "R4");
      go_to(26'h10_0000);
      step(mk_i(6'd4, 16'h8000), '0, '0, 1'b1, 1'b1, 32'h003E_0004, "R6");
      go_to(26'h10_0000);
      step(mk_i(6'd5, 16'hFFFF), 32'd3, 32'd4, 1'b1, 1'b1, 32'h0040_0000, "R6");

      // R7: segment bits come from pc + 4 at the last word of a segment
      go_to(26'h3FF_FFFF);
      chk(pc == 32'h0FFF_FFFC, "R7", pc, 32'h0FFF_FFFC);
      go_to(26'd5);
      chk(pc == 32'h1000_0014, "R7", pc, 32'h1000_0014);
      go_to(26'd0);
      chk(pc == 32'h1000_0000, "R7", pc, 32'h1000_0000);

      // R1: asynchronous reset returns to zero
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk(pc == 32'd0, "R1", pc, 32'd0);
      exp_pc = '0;
      @(negedge clk);
      rst_n = 1'b1;
      step(32'h0, '0, '0, 1'b1, 1'b0, 32'd4, "R3");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule